// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the cycle control of a 32-bit-wide synchronous flow-through SRAM with a 16-bit word address. On every rising clock edge it samples two active-low address strobes: one for a processor and one for a cache controller. It also samples three chip enables, a burst-advance input and the write controls. From these it decides whether the edge opens a new access, continues a burst, closes the session or does nothing. It drives a behavioural memory array with per-byte write enables. Read data comes straight out of the array for the address that was registered at the last edge.

The data bus is modelled as a write-data input, a read-data output and a flag `drive_o` that says when the outputs would drive the pads. A burst counter generates the two low address bits. It follows either a linear order or an interleaved order. The behavioural array keeps the low `MEM_AW` bits of the word address (8 by default). The address port and the burst logic keep the full 16 bits.

Top module: `sbs_ctl`

## Requirements
- R1: The device counts as selected only when `ce_a_ni`=0, `ce_b_i`=1 and `ce_c_ni`=0. An accepted strobe while the device is not selected captures no address, writes nothing and closes the session. After that, `drive_o` stays 0 until a selected strobe opens a new session.
- R2: When both strobes are low with `ce_a_ni`=0, only the processor strobe is taken. It captures the address for a read, and the write controls sampled at that edge are ignored.
- R3: While `ce_a_ni`=1 the processor strobe has no effect. On its own it leaves the open session and the output unchanged. If the controller strobe is low as well, that edge is a deselect as in R1.
- R4: For a byte write, `bwen_ni`=0 and each `bsel_ni[i]`=0 writes data bits `8i+7:8i`. Bytes whose select is 1 keep their old contents.
- R5: `gwen_ni`=0 writes all 32 bits, whatever `bwen_ni` and `bsel_ni` are.
- R6: A selected controller strobe writes at the captured address in the same edge. A continuation cycle, meaning no accepted strobe while a session is open, writes at that cycle's burst address.
- R7: `rdata_o` shows the word at the address registered by the most recent edge (flow-through), so it is valid one clock after that address is captured.
- R8: The burst address is made of the captured upper 14 bits plus two low bits, base B and offset K. K is cleared by a capture and incremented modulo 4 by a continuation edge with `adv_ni`=0. The low bits are B+K mod 4 when `burst_mode_i`=0 (linear) and B xor K when `burst_mode_i`=1 (interleaved). With `adv_ni`=1 the address holds.
- R9: `drive_o` is 1 only while a session is open, the last accepted edge did not write, `oe_ni`=0 and `sleep_i`=0. `oe_ni` and `sleep_i` act without a clock.
- R10: While `sleep_i`=1, clock edges change neither the state nor the array. Operation resumes where it stopped once `sleep_i` returns to 0.
- R11: After reset no session is open and `drive_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Asynchronous snooze, active high |
| ce_a_ni | input | 1 | Chip enable A, active low; also gates the processor strobe |
| ce_b_i | input | 1 | Chip enable B, active high |
| ce_c_ni | input | 1 | Chip enable C, active low |
| strobe_cpu_ni | input | 1 | Processor address strobe, active low, higher priority |
| strobe_ctl_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| burst_mode_i | input | 1 | 1 interleaved order, 0 linear order |
| addr_i | input | 16 | Word address |
| gwen_ni | input | 1 | Global write, active low |
| bwen_ni | input | 1 | Byte write enable, active low |
| bsel_ni | input | 4 | Byte selects, active low |
| wdata_i | input | 32 | Write data |
| oe_ni | input | 1 | Output enable, asynchronous, active low |
| rdata_o | output | 32 | Flow-through read data |
| drive_o | output | 1 | High when read data would be driven |

## Verification
A wrong burst offset or base shows in `rdata_o` one edge after the advance that produced it, because the output is read directly from the registered address. A stale session or write flag shows in `drive_o` right after the next edge. A write that goes to the wrong place, or leaks through a gated strobe, stays hidden until that location is read. For this reason every write target, and every location a blocked write could have reached, is read back through a fresh processor-strobe access.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_LOAD,
    ACC_STEP,
    ACC_CLOSE
  } acc_e;
endpackage

// File: rtl/sbs_cycle_dec.sv
module sbs_cycle_dec
  import sbs_pkg::*;
#(
  parameter int unsigned NB = 4
) (
  input  logic          sleep_i,
  input  logic          ce_a_ni,
  input  logic          ce_b_i,
  input  logic          ce_c_ni,
  input  logic          strobe_cpu_ni,
  input  logic          strobe_ctl_ni,
  input  logic          adv_ni,
  input  logic          sess_i,
  input  logic          gwen_ni,
  input  logic          bwen_ni,
  input  logic [NB-1:0] bsel_ni,
  output acc_e          kind_o,
  output logic [NB-1:0] wmask_o
);
  logic          cpu_hit, ctl_hit, sel;
  logic [NB-1:0] req_mask;

  always_comb begin
    cpu_hit = !strobe_cpu_ni && !ce_a_ni;
    ctl_hit = !strobe_ctl_ni && !cpu_hit;
    sel     = !ce_a_ni && ce_b_i && !ce_c_ni;
    if (!gwen_ni)      req_mask = '1;
    else if (!bwen_ni) req_mask = ~bsel_ni;
    else               req_mask = '0;

    kind_o  = ACC_NONE;
    wmask_o = '0;
    if (!sleep_i) begin
      if (cpu_hit || ctl_hit) begin
        if (sel) begin
          kind_o = ACC_LOAD;
          // processor-strobe edges are reads only
          if (ctl_hit) wmask_o = req_mask;
        end else begin
          kind_o = ACC_CLOSE;
        end
      end else if (sess_i) begin
        if (!adv_ni) kind_o = ACC_STEP;
        wmask_o = req_mask;
      end
    end
  end
endmodule

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
  import sbs_pkg::*;
#(
  parameter int unsigned BW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  acc_e          kind_i,
  input  logic [BW-1:0] base_i,
  input  logic          mode_i,
  output logic [BW-1:0] cur_o,
  output logic [BW-1:0] nxt_o
);
  logic [BW-1:0] base_q, cnt_q, cnt_d;

  function automatic logic [BW-1:0] order(input logic [BW-1:0] b, input logic [BW-1:0] k,
                                          input logic m);
    return m ? (b ^ k) : (b + k);
  endfunction

  always_comb begin
    unique case (kind_i)
      ACC_LOAD: cnt_d = '0;
      ACC_STEP: cnt_d = cnt_q + 1'b1;
      default:  cnt_d = cnt_q;
    endcase
  end

  assign cur_o = order(base_q, cnt_q, mode_i);
  assign nxt_o = (kind_i == ACC_LOAD) ? base_i : order(base_q, cnt_d, mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (kind_i == ACC_LOAD) base_q <= base_i;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int unsigned AW = 8,
  parameter int unsigned NB = 4
) (
  input  logic            clk_i,
  input  logic [NB-1:0]   we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [AW-1:0]   raddr_i,
  input  logic [NB*8-1:0] wdata_i,
  output logic [NB*8-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem[waddr_i] <= wdata_i[g*8 +: 8];
    end
    assign rdata_o[g*8 +: 8] = mem[raddr_i];
  end
endmodule

// File: rtl/sbs_ctl.sv
module sbs_ctl
  import sbs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned BURST_W = 2,
  parameter int unsigned MEM_AW  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sleep_i,
  input  logic                     ce_a_ni,
  input  logic                     ce_b_i,
  input  logic                     ce_c_ni,
  input  logic                     strobe_cpu_ni,
  input  logic                     strobe_ctl_ni,
  input  logic                     adv_ni,
  input  logic                     burst_mode_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     gwen_ni,
  input  logic                     bwen_ni,
  input  logic [DATA_W/LANE_W-1:0] bsel_ni,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic                     oe_ni,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     drive_o
);
  localparam int unsigned NB   = DATA_W / LANE_W;
  localparam int unsigned UP_W = ADDR_W - BURST_W;

  acc_e               kind;
  logic [NB-1:0]      wmask;
  logic               sess_q, wr_q;
  logic [UP_W-1:0]    up_q, up_nxt;
  logic [BURST_W-1:0] cur_lo, nxt_lo;
  logic [ADDR_W-1:0]  acc_addr, rd_addr;
  logic               unused_hi;

  sbs_cycle_dec #(.NB(NB)) u_dec (
    .sleep_i       (sleep_i),
    .ce_a_ni       (ce_a_ni),
    .ce_b_i        (ce_b_i),
    .ce_c_ni       (ce_c_ni),
    .strobe_cpu_ni (strobe_cpu_ni),
    .strobe_ctl_ni (strobe_ctl_ni),
    .adv_ni        (adv_ni),
    .sess_i        (sess_q),
    .gwen_ni       (gwen_ni),
    .bwen_ni       (bwen_ni),
    .bsel_ni       (bsel_ni),
    .kind_o        (kind),
    .wmask_o       (wmask)
  );

  sbs_burst_ctr #(.BW(BURST_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kind_i (kind),
    .base_i (addr_i[BURST_W-1:0]),
    .mode_i (burst_mode_i),
    .cur_o  (cur_lo),
    .nxt_o  (nxt_lo)
  );

  assign up_nxt   = (kind == ACC_LOAD) ? addr_i[ADDR_W-1:BURST_W] : up_q;
  assign acc_addr = {up_nxt, nxt_lo};
  assign rd_addr  = {up_q, cur_lo};
  // array keeps only the low MEM_AW word-address bits
  assign unused_hi = ^{acc_addr[ADDR_W-1:MEM_AW], rd_addr[ADDR_W-1:MEM_AW]};

  sbs_array #(.AW(MEM_AW), .NB(NB)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wmask),
    .waddr_i (acc_addr[MEM_AW-1:0]),
    .raddr_i (rd_addr[MEM_AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sess_q <= 1'b0;
      wr_q   <= 1'b0;
      up_q   <= '0;
    end else if (!sleep_i) begin
      if (kind == ACC_LOAD)       sess_q <= 1'b1;
      else if (kind == ACC_CLOSE) sess_q <= 1'b0;
      wr_q <= |wmask;
      up_q <= up_nxt;
    end
  end

  assign drive_o = sess_q && !wr_q && !oe_ni && !sleep_i;
endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sleep_i,
  input logic              ce_a_ni,
  input logic              ce_b_i,
  input logic              ce_c_ni,
  input logic              strobe_cpu_ni,
  input logic              strobe_ctl_ni,
  input logic              adv_ni,
  input logic              burst_mode_i,
  input logic              gwen_ni,
  input logic              bwen_ni,
  input logic              oe_ni,
  input logic [DATA_W-1:0] rdata_o,
  input logic              drive_o
);
  // R7
  hold_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_cpu_ni && strobe_ctl_ni && adv_ni && gwen_ni && bwen_ni
    |=> (!$stable(burst_mode_i) || $stable(rdata_o)));

  // R10
  sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (!$stable(burst_mode_i) || $stable(rdata_o)));

  // R1
  desel_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i && !strobe_ctl_ni && (strobe_cpu_ni || ce_a_ni) && (ce_a_ni || !ce_b_i || ce_c_ni)
    |=> !drive_o);

  // R9
  write_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i && !strobe_ctl_ni && strobe_cpu_ni && !ce_a_ni && ce_b_i && !ce_c_ni && !gwen_ni
    |=> !drive_o);

  // R2
  cpu_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i && !strobe_cpu_ni && !ce_a_ni && ce_b_i && !ce_c_ni
    |=> (oe_ni || sleep_i || drive_o));

  // R3
  cpu_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_a_ni && !strobe_cpu_ni && strobe_ctl_ni && adv_ni && gwen_ni && bwen_ni
    |=> (!$stable(burst_mode_i) || $stable(rdata_o)));
endmodule

bind sbs_ctl sbs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sleep_i       (sleep_i),
  .ce_a_ni       (ce_a_ni),
  .ce_b_i        (ce_b_i),
  .ce_c_ni       (ce_c_ni),
  .strobe_cpu_ni (strobe_cpu_ni),
  .strobe_ctl_ni (strobe_ctl_ni),
  .adv_ni        (adv_ni),
  .burst_mode_i  (burst_mode_i),
  .gwen_ni       (gwen_ni),
  .bwen_ni       (bwen_ni),
  .oe_ni         (oe_ni),
  .rdata_o       (rdata_o),
  .drive_o       (drive_o)
);

// File: tb/sbs_ctl_test.sv
`timescale 1ns/1ps
module sbs_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep, ce1_n, ce2, ce3_n, cpu_n, ctl_n, adv_n, mode, gw_n, bwe_n, oe_n;
  logic [15:0] addr;
  logic [3:0]  bs_n;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        drive;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sbs_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .ce_a_ni(ce1_n), .ce_b_i(ce2),
    .ce_c_ni(ce3_n), .strobe_cpu_ni(cpu_n), .strobe_ctl_ni(ctl_n), .adv_ni(adv_n),
    .burst_mode_i(mode), .addr_i(addr), .gwen_ni(gw_n), .bwen_ni(bwe_n), .bsel_ni(bs_n),
    .wdata_i(wdata), .oe_ni(oe_n), .rdata_o(rdata), .drive_o(drive)
  );

  // reference model state
  logic [31:0] m_mem [256];
  logic        m_sess = 1'b0, m_wr = 1'b0;
  logic [13:0] m_up = '0;
  logic [1:0]  m_base = '0, m_cnt = '0;

  // scoreboard queues
  logic [31:0] q_data [$];
  logic        q_drive [$];
  logic        q_chk [$];
  string       q_tag [$];

  function automatic logic [1:0] lo_bits();
    return mode ? (m_base ^ m_cnt) : (m_base + m_cnt);
  endfunction

  task automatic idle();
    sleep = 0; ce1_n = 0; ce2 = 1; ce3_n = 0; cpu_n = 1; ctl_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bs_n = 4'hF; oe_n = 0; addr = '0; wdata = '0;
  endtask

  task automatic tick(input string tag);
    logic cpu, ctl, sel;
    logic [3:0] m;
    logic [15:0] cur;
    logic [31:0] ed;
    if (!sleep) begin
      cpu = !cpu_n && !ce1_n;
      ctl = !ctl_n && !cpu;
      sel = !ce1_n && ce2 && !ce3_n;
      m = !gw_n ? 4'hF : (!bwe_n ? ~bs_n : 4'h0);
      if (cpu || ctl) begin
        if (sel) begin
          m_sess = 1; m_up = addr[15:2]; m_base = addr[1:0]; m_cnt = 0;
          if (cpu) m = 0;
        end else begin
          m_sess = 0; m = 0;
        end
      end else if (m_sess) begin
        if (!adv_n) m_cnt = m_cnt + 2'd1;
      end else begin
        m = 0;
      end
      m_wr = (m != 0);
      cur = {m_up, lo_bits()};
      for (int b = 0; b < 4; b++)
        if (m[b]) m_mem[cur[7:0]][b*8 +: 8] = wdata[b*8 +: 8];
    end
    cur = {m_up, lo_bits()};
    ed = m_mem[cur[7:0]];
    q_data.push_back(ed);
    q_drive.push_back(m_sess && !m_wr && !oe_n && !sleep);
    q_chk.push_back(m_sess && (^ed !== 1'bx));
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic wr_start(input logic [15:0] a, input logic [31:0] d, input string tag);
    idle(); ctl_n = 0; addr = a; gw_n = 0; wdata = d; tick(tag);
  endtask

  task automatic rd_start(input logic [15:0] a, input string tag);
    idle(); cpu_n = 0; addr = a; tick(tag);
  endtask

  // monitor
  always @(posedge clk) begin
    string t;
    logic [31:0] ed;
    logic ev, ec;
    #2;
    if (q_tag.size() != 0) begin
      t = q_tag.pop_front(); ed = q_data.pop_front();
      ev = q_drive.pop_front(); ec = q_chk.pop_front();
      total++;
      if (drive !== ev) begin
        bad++;
        $display("FAIL %s drive_o act=%0b exp=%0b", t, drive, ev);
      end
      if (ec) begin
        total++;
        if (rdata !== ed) begin
          bad++;
          $display("FAIL %s rdata_o act=%h exp=%h", t, rdata, ed);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(); mode = 0;
    repeat (3) @(negedge clk);
    total++;
    if (drive !== 1'b0) begin bad++; $display("FAIL R11 drive_o act=%0b exp=0", drive); end
    rst_n = 1;
    @(negedge clk);
    idle(); tick("R11");

    // global and byte writes
    wr_start(16'h0010, 32'h1111_1111, "R5");
    wr_start(16'h0011, 32'hAAAA_5555, "R6");
    idle(); ctl_n = 0; addr = 16'h0011; bwe_n = 0; bs_n = 4'b1010; wdata = 32'h1234_5678; tick("R4");
    rd_start(16'h0011, "R4");
    idle(); ctl_n = 0; addr = 16'h0011; gw_n = 0; bwe_n = 0; bs_n = 4'b1110;
    wdata = 32'hCAFE_F00D; tick("R5");
    rd_start(16'h0011, "R5");

    // strobe priority
    wr_start(16'h0020, 32'h2020_2020, "R6");
    idle(); cpu_n = 0; ctl_n = 0; addr = 16'h0020; gw_n = 0; wdata = 32'hDEAD_0000; tick("R2");
    idle(); tick("R7");

    // chip enable A gates the processor strobe
    idle(); ce1_n = 1; cpu_n = 0; addr = 16'h0010; tick("R3");
    idle(); ce1_n = 1; cpu_n = 0; ctl_n = 0; addr = 16'h0020; gw_n = 0; wdata = 32'h0BAD_0BAD; tick("R3");
    rd_start(16'h0020, "R3");

    // deselect
    idle(); ctl_n = 0; ce2 = 0; addr = 16'h0010; gw_n = 0; wdata = 32'h0; tick("R1");
    idle(); tick("R1");
    idle(); ctl_n = 0; ce3_n = 1; addr = 16'h0010; gw_n = 0; wdata = 32'h5; tick("R1");
    rd_start(16'h0010, "R1");

    // burst write 0x30..0x33
    wr_start(16'h0030, 32'h3000_0030, "R6");
    for (int i = 1; i < 4; i++) begin
      idle(); adv_n = 0; gw_n = 0; wdata = 32'h3000_0030 + i; tick("R6");
    end
    // linear burst read from 0x32
    mode = 0;
    rd_start(16'h0032, "R7");
    for (int i = 0; i < 3; i++) begin idle(); adv_n = 0; tick("R8"); end
    idle(); tick("R8");
    // interleaved burst read from 0x31
    mode = 1;
    rd_start(16'h0031, "R7");
    for (int i = 0; i < 4; i++) begin idle(); adv_n = 0; tick("R8"); end

    // output enable and post-write turnaround
    idle(); oe_n = 1; tick("R9");
    wr_start(16'h0040, 32'h4444_4444, "R9");
    idle(); tick("R9");
    idle(); adv_n = 0; gw_n = 0; wdata = 32'h4545_4545; tick("R9");
    idle(); adv_n = 0; tick("R9");
    rd_start(16'h0041, "R6");

    // snooze
    idle(); sleep = 1; ctl_n = 0; addr = 16'h0010; gw_n = 0; wdata = 32'h9999_9999; tick("R10");
    idle(); sleep = 1; adv_n = 0; tick("R10");
    idle(); tick("R10");
    rd_start(16'h0010, "R10");

    idle(); tick("R7");
    idle(); tick("R7");
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule